// File: doc/BRIEF.md
# Reset management controller

This block sits in the always-on part of a chip and decides which reset domains to pulse when a reset request arrives. Four request sources feed it: a watchdog, a core lockup detector, a core system-reset request and an external reset pin. Each source has its own 3-bit mode in a control register. The mode either blocks the request or selects a scope. The scope is limited, extended or full, and each wider scope covers more domains. The block drives four active-low domain resets: main logic, real-time clock, low-power timer and debug. Power-on and the three brown-out indications always act with full scope.

A sticky cause register records every event that led to a reset. It also records the raw backup-mode and deep-sleep flags. Software clears it with a command write, and a power-on collapses it to the power-on bit alone. A 16-bit key written to the lock register freezes the control register against stray writes. The register port is a plain 32-bit write strobe with a byte address and combinational read data. The block's own registers are never touched by the domain resets it produces.

Top module: `rst_mgmt_ctrl`

## Requirements
- R1: The control register at byte offset 0x0 holds the watchdog mode in bits 2:0, the lockup mode in bits 6:4, the system-request mode in bits 10:8, the pin mode in bits 14:12 and a 2-bit software reset-state field in bits 25:24; all other bits read 0, as does any unmapped offset.
- R2: Mode values 0, 3, 5, 6 and 7 block a request: no domain reset is pulsed and no cause bit is set for it.
- R3: Mode 1 (limited) pulses only the main domain reset.
- R4: Mode 2 (extended) pulses the main and real-time clock domain resets.
- R5: Mode 4 (full) pulses all four domain resets; a power-on or any brown-out indication acts with full scope regardless of the modes.
- R6: A request sampled on a clock edge drives the selected domain resets low for exactly 4 cycles starting just after that edge; simultaneous requests pulse the union of their domains (the widest scope wins), and a new request reloads the pulse.
- R7: The read-only cause register at offset 0x4 uses power-on bit 0, analog brown-out bit 2, digital brown-out bit 3, decouple brown-out bit 4, pin bit 8, lockup bit 9, system-request bit 10, watchdog bit 11, backup-mode bit 12 and deep-sleep bit 16; bits are sticky and are set only by non-blocked requests or the raw flags.
- R8: Writing 1 to bit 0 of the command register at offset 0x8 clears the cause register; an event in the same cycle is still recorded; offset 0x8 always reads 0.
- R9: A power-on indication leaves the cause register holding only bit 0.
- R10: Writing 0xE084 to bits 15:0 of the lock register at offset 0x10 unlocks, any other value locks; the register reads 1 when locked and 0 when unlocked; while locked, control-register writes are ignored.
- R11: After the block's own reset the control register is 0, the block is unlocked, the cause register is 0 and all domain resets are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset of the block's own registers |
| wdog_req_i | input | 1 | Watchdog reset request, sampled every cycle |
| lockup_req_i | input | 1 | Core lockup reset request |
| sysreq_req_i | input | 1 | Core system-reset request |
| pin_req_i | input | 1 | External pin reset request (already synchronized) |
| por_i | input | 1 | Power-on indication |
| bod_avdd_i | input | 1 | Analog-supply brown-out indication |
| bod_dvdd_i | input | 1 | Digital-supply brown-out indication |
| bod_dec_i | input | 1 | Decouple-domain brown-out indication |
| backup_evt_i | input | 1 | Backup-mode reset flag (cause only) |
| deepsleep_evt_i | input | 1 | Deep-sleep reset flag (cause only) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Byte address of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| main_rst_n | output | 1 | Main logic domain reset, active low |
| rtc_rst_n | output | 1 | Real-time clock domain reset, active low |
| lpt_rst_n | output | 1 | Low-power timer domain reset, active low |
| dbg_rst_n | output | 1 | Debug domain reset, active low |

## Verification
On every cycle the assertions check four things. Domain resets must nest: debug equals low-power timer, low-power timer implies real-time clock, and real-time clock implies main. A trigger must start a pulse on the next cycle, and a pulse must end when it runs out. Cause bits must be sticky, clear after a clean command and collapse after power-on. A locked block must hold its control register. Only the bench scenarios can show how each mode value maps to domains, that the pulse lasts exactly four cycles, and that the cause and control registers sit at the right bit positions. They also cover set-beats-clear in one cycle and the exact lock key. For these the bench compares a behavioural model against the ports every cycle.

// File: rtl/rmc_pkg.sv
// Package: shared constants, scope type and decode functions for the
// reset management controller. Assumes byte-addressed 32-bit registers.
package rmc_pkg;

    localparam int REG_W    = 32;
    localparam int NUM_SRC  = 4;   // wdog, lockup, sysreq, pin
    localparam int NUM_DOM  = 4;   // main, rtc, lpt, dbg
    localparam int MODE_W   = 3;
    localparam int MODE_STRIDE = 4;

    // Source indices (also the mode field index in the control register)
    localparam int SRC_WDOG   = 0;
    localparam int SRC_LOCKUP = 1;
    localparam int SRC_SYSREQ = 2;
    localparam int SRC_PIN    = 3;

    // Domain indices
    localparam int DOM_MAIN = 0;
    localparam int DOM_RTC  = 1;
    localparam int DOM_LPT  = 2;
    localparam int DOM_DBG  = 3;

    // Register byte offsets
    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_CAUSE = 'h04;
    localparam int OFS_CMD   = 'h08;
    localparam int OFS_LOCK  = 'h10;

    localparam logic [15:0] UNLOCK_KEY = 16'hE084;

    // Reset-state field position
    localparam int RSTATE_LSB = 24;
    localparam int RSTATE_W   = 2;

    // Cause bit positions
    localparam int CB_POR       = 0;
    localparam int CB_BOD_A     = 2;
    localparam int CB_BOD_D     = 3;
    localparam int CB_BOD_DEC   = 4;
    localparam int CB_PIN       = 8;
    localparam int CB_LOCKUP    = 9;
    localparam int CB_SYSREQ    = 10;
    localparam int CB_WDOG      = 11;
    localparam int CB_BACKUP    = 12;
    localparam int CB_DEEPSLEEP = 16;

    typedef enum logic [1:0] {
        SCOPE_NONE,
        SCOPE_LIMITED,
        SCOPE_EXTENDED,
        SCOPE_FULL
    } scope_e;

    // Map a mode field to a scope; undefined codes block.
    function automatic scope_e mode_to_scope(input logic [MODE_W-1:0] m);
        case (m)
            3'd1:    return SCOPE_LIMITED;
            3'd2:    return SCOPE_EXTENDED;
            3'd4:    return SCOPE_FULL;
            default: return SCOPE_NONE;
        endcase
    endfunction

    // Domains covered by a scope; each wider scope is a superset.
    function automatic logic [NUM_DOM-1:0] scope_to_domains(input scope_e s);
        logic [NUM_DOM-1:0] d;
        d = '0;
        if (s != SCOPE_NONE)                         d[DOM_MAIN] = 1'b1;
        if (s == SCOPE_EXTENDED || s == SCOPE_FULL)  d[DOM_RTC]  = 1'b1;
        if (s == SCOPE_FULL) begin
            d[DOM_LPT] = 1'b1;
            d[DOM_DBG] = 1'b1;
        end
        return d;
    endfunction

    // Cause bit recorded for each request source.
    function automatic int src_cause_bit(input int src);
        case (src)
            SRC_WDOG:   return CB_WDOG;
            SRC_LOCKUP: return CB_LOCKUP;
            SRC_SYSREQ: return CB_SYSREQ;
            default:    return CB_PIN;
        endcase
    endfunction

endpackage

// File: rtl/rmc_regs.sv
// Register file: control (mode fields + reset-state), lock state,
// command decode and read-back mux. Assumes one access per cycle and
// combinational reads. Control writes are dropped while locked.
module rmc_regs
    import rmc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_we,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [REG_W-1:0]          reg_wdata,
    input  logic [REG_W-1:0]          cause_i,
    output logic [NUM_SRC*MODE_W-1:0] modes_o,
    output logic                      cause_clr_o,
    output logic [REG_W-1:0]          reg_rdata
);

    // Mask of implemented control bits, derived from field positions
    function automatic logic [REG_W-1:0] ctrl_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            for (int b = 0; b < MODE_W; b++) begin
                m[s*MODE_STRIDE + b] = 1'b1;
            end
        end
        for (int b = 0; b < RSTATE_W; b++) begin
            m[RSTATE_LSB + b] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [REG_W-1:0] CTRL_MASK = ctrl_mask();

    logic [REG_W-1:0] ctrl_q;
    logic             locked_q;
    logic             hit_ctrl, hit_cause, hit_cmd, hit_lock;

    // Address decode
    always_comb begin
        hit_ctrl  = (reg_addr == ADDR_W'(OFS_CTRL));
        hit_cause = (reg_addr == ADDR_W'(OFS_CAUSE));
        hit_cmd   = (reg_addr == ADDR_W'(OFS_CMD));
        hit_lock  = (reg_addr == ADDR_W'(OFS_LOCK));
    end

    // Control register, writable only when unlocked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_we && hit_ctrl && !locked_q) begin
            ctrl_q <= reg_wdata & CTRL_MASK;
        end
    end

    // Lock state: the key unlocks, any other value locks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
        end else if (reg_we && hit_lock) begin
            locked_q <= (reg_wdata[15:0] != UNLOCK_KEY);
        end
    end

    // Extract the per-source mode fields
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            modes_o[s*MODE_W +: MODE_W] = ctrl_q[s*MODE_STRIDE +: MODE_W];
        end
    end

    // Command decode: clear request for the cause register
    always_comb cause_clr_o = reg_we && hit_cmd && reg_wdata[0];

    // Read-back mux; command and unmapped offsets read zero
    always_comb begin
        reg_rdata = '0;
        if (hit_ctrl)  reg_rdata = ctrl_q;
        if (hit_cause) reg_rdata = cause_i;
        if (hit_lock)  reg_rdata = {{(REG_W-1){1'b0}}, locked_q};
    end

    AST_LOCK_HOLDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && reg_we && hit_ctrl) |=> $stable(ctrl_q)); // R10
    AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && hit_lock && reg_wdata[15:0] == UNLOCK_KEY) |=> (reg_rdata[0] == 1'b0 || !hit_lock)); // R10
    AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cmd |-> (reg_rdata == '0)); // R8

endmodule

// File: rtl/rmc_cause.sv
// Sticky reset-cause register. Events OR into the held value; a clear
// command empties it but same-cycle events survive; power-on overrides
// everything and leaves only the power-on bit.
module rmc_cause
    import rmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_i,
    input  logic             clr_i,
    input  logic [REG_W-1:0] evt_i,
    output logic [REG_W-1:0] cause_o
);

    logic [REG_W-1:0] cause_q;

    // Cause update: power-on first, then clear, then accumulate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else if (por_i) begin
            cause_q <= REG_W'(1) << CB_POR;
        end else begin
            cause_q <= (clr_i ? '0 : cause_q) | evt_i;
        end
    end

    assign cause_o = cause_q;

    AST_POR_ONLY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> (cause_q == (REG_W'(1) << CB_POR))); // R9
    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!por_i && !clr_i) |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R7
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (!por_i && clr_i && evt_i == '0) |=> (cause_q == '0)); // R8

endmodule

// File: rtl/rmc_pulse.sv
// Per-domain reset pulse generators. A trigger (re)loads a down-counter
// to PULSE_LEN; the domain is held in reset while the counter is non-zero.
module rmc_pulse #(
    parameter int NUM_DOM   = 4,
    parameter int PULSE_LEN = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DOM-1:0] trig_i,
    output logic [NUM_DOM-1:0] active_o
);

    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        logic [CNT_W-1:0] cnt_q;

        // Down-counter for one domain, reloaded on trigger
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (trig_i[d]) begin
                cnt_q <= CNT_W'(PULSE_LEN);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        assign active_o[d] = (cnt_q != '0);

        AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
            trig_i[d] |=> active_o[d]); // R6
        AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q == CNT_W'(1) && !trig_i[d]) |=> !active_o[d]); // R6
    end

endmodule

// File: rtl/rst_mgmt_ctrl.sv
// Top of the reset management controller. Decodes each source's mode to a
// scope, merges the resulting domain sets with power-on/brown-out (always
// full scope), drives the per-domain pulse generators and feeds the cause
// register. Assumes request inputs are synchronous to clk.
module rst_mgmt_ctrl
    import rmc_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wdog_req_i,
    input  logic              lockup_req_i,
    input  logic              sysreq_req_i,
    input  logic              pin_req_i,
    input  logic              por_i,
    input  logic              bod_avdd_i,
    input  logic              bod_dvdd_i,
    input  logic              bod_dec_i,
    input  logic              backup_evt_i,
    input  logic              deepsleep_evt_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              main_rst_n,
    output logic              rtc_rst_n,
    output logic              lpt_rst_n,
    output logic              dbg_rst_n
);

    logic [NUM_SRC*MODE_W-1:0] modes;
    logic [NUM_SRC-1:0]        src_req;
    logic [NUM_DOM-1:0]        src_dom [NUM_SRC];
    logic [NUM_SRC-1:0]        src_live;
    logic [NUM_DOM-1:0]        dom_trig;
    logic [NUM_DOM-1:0]        dom_active;
    logic                      full_req;
    logic                      cause_clr;
    logic [REG_W-1:0]          cause_evt;
    logic [REG_W-1:0]          cause_val;

    // Gather the request sources in mode-field order
    always_comb begin
        src_req[SRC_WDOG]   = wdog_req_i;
        src_req[SRC_LOCKUP] = lockup_req_i;
        src_req[SRC_SYSREQ] = sysreq_req_i;
        src_req[SRC_PIN]    = pin_req_i;
    end

    // Per-source scope decode
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        scope_e scope;
        always_comb begin
            scope       = mode_to_scope(modes[s*MODE_W +: MODE_W]);
            src_dom[s]  = src_req[s] ? scope_to_domains(scope) : '0;
            src_live[s] = src_req[s] && (scope != SCOPE_NONE);
        end
    end

    // Merge all requests into one trigger per domain (widest wins)
    always_comb begin
        full_req = por_i | bod_avdd_i | bod_dvdd_i | bod_dec_i;
        dom_trig = full_req ? '1 : '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            dom_trig = dom_trig | src_dom[s];
        end
    end

    // Cause events: live requests plus raw flags
    always_comb begin
        cause_evt = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            cause_evt[src_cause_bit(s)] = src_live[s];
        end
        cause_evt[CB_BOD_A]     = bod_avdd_i;
        cause_evt[CB_BOD_D]     = bod_dvdd_i;
        cause_evt[CB_BOD_DEC]   = bod_dec_i;
        cause_evt[CB_BACKUP]    = backup_evt_i;
        cause_evt[CB_DEEPSLEEP] = deepsleep_evt_i;
    end

    rmc_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .cause_i     (cause_val),
        .modes_o     (modes),
        .cause_clr_o (cause_clr),
        .reg_rdata   (reg_rdata)
    );

    rmc_cause u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .por_i   (por_i),
        .clr_i   (cause_clr),
        .evt_i   (cause_evt),
        .cause_o (cause_val)
    );

    rmc_pulse #(.NUM_DOM(NUM_DOM), .PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (dom_trig),
        .active_o (dom_active)
    );

    // Active-low domain reset outputs
    always_comb begin
        main_rst_n = !dom_active[DOM_MAIN];
        rtc_rst_n  = !dom_active[DOM_RTC];
        lpt_rst_n  = !dom_active[DOM_LPT];
        dbg_rst_n  = !dom_active[DOM_DBG];
    end

    AST_RTC_WITHIN_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !rtc_rst_n |-> !main_rst_n); // R4
    AST_LPT_WITHIN_RTC: assert property (@(posedge clk) disable iff (!rst_n)
        !lpt_rst_n |-> !rtc_rst_n); // R5
    AST_DBG_WITH_LPT: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_rst_n == lpt_rst_n); // R5
    AST_FULL_HITS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        full_req |=> (!main_rst_n && !rtc_rst_n && !lpt_rst_n && !dbg_rst_n)); // R5

endmodule

// File: tb/sim_rst_mgmt_ctrl.sv
module sim_rst_mgmt_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int PLEN       = 4;
    localparam int WDOG_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wdog_req = 0, lockup_req = 0, sysreq_req = 0, pin_req = 0;
    logic        por = 0, bod_a = 0, bod_d = 0, bod_dec = 0, backup = 0, deep = 0;
    logic        reg_we = 0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        main_rst_n, rtc_rst_n, lpt_rst_n, dbg_rst_n;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R11";
    bit    started = 0;
    bit    done = 0;

    // reference model state
    int unsigned m_ctrl = 0;
    int unsigned m_cause = 0;
    bit          m_locked = 0;
    int          m_cnt [4] = '{0, 0, 0, 0};
    int          t_mask, t_ev, t_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_mgmt_ctrl #(.ADDR_W(10), .PULSE_LEN(PLEN)) u0 (
        .clk(clk), .rst_n(rst_n),
        .wdog_req_i(wdog_req), .lockup_req_i(lockup_req),
        .sysreq_req_i(sysreq_req), .pin_req_i(pin_req),
        .por_i(por), .bod_avdd_i(bod_a), .bod_dvdd_i(bod_d), .bod_dec_i(bod_dec),
        .backup_evt_i(backup), .deepsleep_evt_i(deep),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .main_rst_n(main_rst_n), .rtc_rst_n(rtc_rst_n),
        .lpt_rst_n(lpt_rst_n), .dbg_rst_n(dbg_rst_n)
    );

    // domain set for a mode value: bit0 main, bit1 rtc, bit2 lpt, bit3 dbg
    function automatic int doms_for(int mode);
        if (mode == 1) return 1;
        if (mode == 2) return 3;
        if (mode == 4) return 15;
        return 0;
    endfunction

    function automatic int unsigned model_read(int a);
        if (a == 'h00) return m_ctrl;
        if (a == 'h04) return m_cause;
        if (a == 'h10) return m_locked ? 1 : 0;
        return 0;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // model of one source request
    task automatic model_src(bit req, int field, int cbit);
        if (req) begin
            t_mode = (m_ctrl >> (4*field)) & 7;
            if (doms_for(t_mode) != 0) begin
                t_mask = t_mask | doms_for(t_mode);
                t_ev   = t_ev | (1 << cbit);
            end
        end
    endtask

    // behavioural reference model, advanced on every rising edge
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_ctrl = 0; m_cause = 0; m_locked = 0;
            foreach (m_cnt[i]) m_cnt[i] = 0;
        end else begin
            t_mask = 0; t_ev = 0;
            model_src(wdog_req, 0, 11);
            model_src(lockup_req, 1, 9);
            model_src(sysreq_req, 2, 10);
            model_src(pin_req, 3, 8);
            if (por || bod_a || bod_d || bod_dec) t_mask = 15;
            if (bod_a)   t_ev = t_ev | (1 << 2);
            if (bod_d)   t_ev = t_ev | (1 << 3);
            if (bod_dec) t_ev = t_ev | (1 << 4);
            if (backup)  t_ev = t_ev | (1 << 12);
            if (deep)    t_ev = t_ev | (1 << 16);
            foreach (m_cnt[i]) begin
                if (t_mask[i]) m_cnt[i] = PLEN;
                else if (m_cnt[i] > 0) m_cnt[i]--;
            end
            if (por) m_cause = 1;
            else begin
                if (reg_we && reg_addr == 'h08 && reg_wdata[0]) m_cause = 0;
                m_cause = m_cause | t_ev;
            end
            if (reg_we && reg_addr == 'h00 && !m_locked) m_ctrl = reg_wdata & 32'h0300_7777;
            if (reg_we && reg_addr == 'h10) m_locked = (reg_wdata[15:0] != 16'hE084);
        end
    end

    // compare model against ports on every falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk(cur_req, "main_rst_n", main_rst_n, m_cnt[0] == 0);
            chk(cur_req, "rtc_rst_n",  rtc_rst_n,  m_cnt[1] == 0);
            chk(cur_req, "lpt_rst_n",  lpt_rst_n,  m_cnt[2] == 0);
            chk(cur_req, "dbg_rst_n",  dbg_rst_n,  m_cnt[3] == 0);
            chk(cur_req, "reg_rdata",  reg_rdata,  model_read(int'(reg_addr)));
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(int a, int unsigned d);
        reg_we = 1; reg_addr = 10'(a); reg_wdata = d;
        step();
        reg_we = 0;
    endtask

    task automatic rd_chk(string req, int a, int unsigned exp);
        reg_addr = 10'(a);
        #1;
        chk(req, "read", reg_rdata, exp);
    endtask

    task automatic doms_chk(string req, bit m, bit r, bit l, bit d);
        chk(req, "main", main_rst_n, !m);
        chk(req, "rtc",  rtc_rst_n,  !r);
        chk(req, "lpt",  lpt_rst_n,  !l);
        chk(req, "dbg",  dbg_rst_n,  !d);
    endtask

    // watchdog
    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R11: reset state
        cur_req = "R11";
        step(3);
        rst_n = 1;
        step();
        rd_chk("R11", 'h00, 0);
        rd_chk("R11", 'h04, 0);
        rd_chk("R11", 'h10, 0);
        doms_chk("R11", 0, 0, 0, 0);

        // R1: field placement and unimplemented bits
        cur_req = "R1";
        wr('h00, 32'hFFFF_FFFF);
        rd_chk("R1", 'h00, 32'h0300_7777);
        rd_chk("R1", 'h3C, 0);
        rd_chk("R1", 'h14, 0);

        // modes: wdog limited, lockup extended, sysreq full, pin blocked
        wr('h00, 32'h0000_0421);
        cur_req = "R3";
        wdog_req = 1; step(); wdog_req = 0;
        doms_chk("R3", 1, 0, 0, 0);
        step(PLEN);
        rd_chk("R7", 'h04, 32'h800);

        cur_req = "R4";
        lockup_req = 1; step(); lockup_req = 0;
        doms_chk("R4", 1, 1, 0, 0);
        step(PLEN);

        cur_req = "R5";
        sysreq_req = 1; step(); sysreq_req = 0;
        doms_chk("R5", 1, 1, 1, 1);
        step(PLEN - 1);
        doms_chk("R6", 1, 1, 1, 1);   // last of 4 cycles
        step();
        doms_chk("R6", 0, 0, 0, 0);   // released after 4
        rd_chk("R7", 'h04, 32'hE00);

        // R2: pin blocked for 0,3,5,6,7
        cur_req = "R2";
        wr('h08, 1);
        for (int v = 0; v < 8; v++) begin
            if (v == 1 || v == 2 || v == 4) continue;
            wr('h00, v << 12);
            pin_req = 1; step(); pin_req = 0;
            doms_chk("R2", 0, 0, 0, 0);
        end
        rd_chk("R2", 'h04, 0);

        // R6: simultaneous requests, widest wins; reload mid-pulse
        cur_req = "R6";
        wr('h00, 32'h0000_4401);   // wdog limited, sysreq full, pin full
        wdog_req = 1; sysreq_req = 1; step(); wdog_req = 0; sysreq_req = 0;
        doms_chk("R6", 1, 1, 1, 1);
        step(2);
        wdog_req = 1; step(); wdog_req = 0;   // reload main only
        step(2);
        doms_chk("R6", 1, 0, 0, 0);
        step(2);
        doms_chk("R6", 0, 0, 0, 0);
        rd_chk("R7", 'h04, 32'hC00);

        // R8: clear, and same-cycle event survives clear
        cur_req = "R8";
        rd_chk("R8", 'h08, 0);
        wr('h08, 1);
        rd_chk("R8", 'h04, 0);
        pin_req = 1;
        wr('h08, 1);
        pin_req = 0;
        rd_chk("R8", 'h04, 32'h100);
        wr('h08, 32'hFFFF_FFFE);   // bit0 clear: no effect
        rd_chk("R8", 'h04, 32'h100);
        step(PLEN);

        // R7/R5: raw flags and brown-outs
        cur_req = "R7";
        backup = 1; deep = 1; step(); backup = 0; deep = 0;
        doms_chk("R7", 0, 0, 0, 0);
        rd_chk("R7", 'h04, 32'h1_1100);
        cur_req = "R5";
        bod_a = 1; step(); bod_a = 0;
        doms_chk("R5", 1, 1, 1, 1);
        bod_d = 1; step(); bod_d = 0;
        bod_dec = 1; step(); bod_dec = 0;
        step(PLEN);
        rd_chk("R7", 'h04, 32'h1_111C);

        // R9: power-on collapses cause
        cur_req = "R9";
        por = 1; wdog_req = 1; step(); por = 0; wdog_req = 0;
        doms_chk("R9", 1, 1, 1, 1);
        rd_chk("R9", 'h04, 1);
        step(PLEN);

        // R10: lock key
        cur_req = "R10";
        wr('h10, 32'h0000_1234);
        rd_chk("R10", 'h10, 1);
        wr('h00, 32'h0000_0002);
        rd_chk("R10", 'h00, 32'h0000_4401);
        wr('h10, 32'hFFFF_E084);
        rd_chk("R10", 'h10, 0);
        wr('h00, 32'h0100_0002);
        rd_chk("R10", 'h00, 32'h0100_0002);
        wr('h10, 32'h0000_E085);
        rd_chk("R10", 'h10, 1);

        // R11: reset mid-run
        cur_req = "R11";
        wdog_req = 1; step(); wdog_req = 0;
        rst_n = 0; step(2); rst_n = 1;
        doms_chk("R11", 0, 0, 0, 0);
        rd_chk("R11", 'h00, 0);
        rd_chk("R11", 'h10, 0);
        rd_chk("R11", 'h04, 0);
        step(3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule